// File: doc/BRIEF.md
# Network Controller Command and Interrupt Register File

This block is the word-addressed control and status register file of a network controller. Software writes 16-bit words through a 6-bit register address and a write strobe, and reads them back through a read strobe with combinational read data. A write to the command word becomes single-cycle action pulses for the sequencers around it: transmit, read of the receive-resource ring, load of the address-match table, timer start and stop, and receiver enable and disable. Those sequencers report completion on a small done bus, which retires the matching latched command bits.

Each register has its own write rule. Some bits are masked away. The configuration words can be written only while the software reset bit is set. The status word is write-one-to-clear. The revision and address-match readback words are read-only. The tally counters store the inverse of what is written. Other blocks raise status bits through a set bus. A level interrupt is driven whenever any status bit is also enabled in the mask word.

Address map: 0x00 command, 0x01 status, 0x02 mask, 0x03 configuration, 0x04 second configuration, 0x05 transmit control, 0x06 receive control, 0x07 sequence, 0x08 to 0x0B ring pointers (start, end, read, write), 0x0C end-of-buffer count, 0x10 to 0x12 tallies, 0x14 revision, 0x15 to 0x17 address-match readback.

Top module: `netctl_regfile`

## Requirements
- R1: `irq` is high exactly when the AND of the mask word (0x02) and the status word (0x01) is nonzero, one cycle after the write or set that changes them.
- R2: A write to the status word (0x01) clears the bits that are written as 1 and are currently set. The `stat_set` bits are ORed in on every cycle, and a set takes priority over a clear of the same bit in the same cycle.
- R3: When a status write clears bit 5 (resources exhausted) while that bit is set, `act_rra` pulses in the same cycle as the write. A write of bit 5 while the bit is already clear gives no pulse.
- R4: Bit 15 of the mask word (0x02) always reads 0.
- R5: If command bit 7 (reset) is set and a command write (0x00) has bit 7 clear, the write only clears bit 7 and gives no action pulse.
- R6: Otherwise, the command write ORs in its bits masked by 0x03BF. The command bits are: 0 halt, 1 transmit, 2 receiver off, 3 receiver on, 4 timer stop, 5 timer start, 7 reset, 8 read resource, 9 load table. Each written action bit pulses its output (`act_tx`, `act_rra`, `act_lcam`, `act_tmr_go`, `act_tmr_halt`, `act_rx_on`, `act_rx_off`) in the same cycle as the write.
- R7: Receiver on clears receiver off, and receiver off clears receiver on. Timer start clears timer stop, and timer stop clears timer start. A reset command clears bits 9, 8, 1 and 0, and sets bits 7 and 2.
- R8: Configuration (0x03, mask 0xBFFF) and second configuration (0x04, mask 0xF017) accept writes only while command bit 7 is set.
- R9: Transmit control (0x05) keeps only bits 15:12. Receive control (0x06) keeps only bits 15:5.
- R10: The ring pointers (0x08 to 0x0B) always store bit 0 as 0. The tallies (0x10 to 0x12) store the bitwise inverse of the written word.
- R11: The revision word (0x14) reads 0x0004. Writes to it and to 0x15 to 0x17 are ignored, and 0x15 to 0x17 read 0. Unmapped addresses read 0. `reg_rdata` is 0 while `reg_rd` is low.
- R12: After hardware reset, the command word is 0x0094. Status, mask, second configuration and sequence words are 0, the end-of-buffer count is 0x02F8, and `irq` is low.
- R13: `seq_done` bits 0, 1 and 2 clear command bits 1, 8 and 9 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| reg_addr | input | 6 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Read data, combinational |
| stat_set | input | 16 | Status bits raised by other blocks |
| seq_done | input | 3 | Completion of transmit, read-resource, table load |
| act_tx | output | 1 | Transmit start pulse |
| act_rra | output | 1 | Read-resource request pulse |
| act_lcam | output | 1 | Table load pulse |
| act_tmr_go | output | 1 | Timer start pulse |
| act_tmr_halt | output | 1 | Timer stop pulse |
| act_rx_on | output | 1 | Receiver enable pulse |
| act_rx_off | output | 1 | Receiver disable pulse |
| irq | output | 1 | Level interrupt |

## Verification
Action pulses are combinational from the write strobe and the stored command word, so they are due in the write cycle itself. The bench samples them a quarter period after driving the write, before the committing edge. Stored values, `irq` and the effects of `seq_done` and `stat_set` are due one edge later, so the bench reads them back at the next falling edge. A read is combinational and is sampled shortly after the address is driven, with no clock edge in between.

// File: rtl/netctl_pkg.sv
package netctl_pkg;
  localparam int DW = 16;
  localparam int AW = 6;

  localparam logic [AW-1:0] A_CMD   = 6'h00;
  localparam logic [AW-1:0] A_STAT  = 6'h01;
  localparam logic [AW-1:0] A_MASK  = 6'h02;
  localparam logic [AW-1:0] A_CFG   = 6'h03;
  localparam logic [AW-1:0] A_CFG2  = 6'h04;
  localparam logic [AW-1:0] A_TXC   = 6'h05;
  localparam logic [AW-1:0] A_RXC   = 6'h06;
  localparam logic [AW-1:0] A_SEQ   = 6'h07;
  localparam logic [AW-1:0] A_PTR0  = 6'h08;
  localparam logic [AW-1:0] A_EOBC  = 6'h0C;
  localparam logic [AW-1:0] A_TAL0  = 6'h10;
  localparam logic [AW-1:0] A_REV   = 6'h14;
  localparam logic [AW-1:0] A_CAM0  = 6'h15;
  localparam logic [AW-1:0] A_CAM2  = 6'h17;

  localparam int B_HALT  = 0;
  localparam int B_TX    = 1;
  localparam int B_RXOFF = 2;
  localparam int B_RXON  = 3;
  localparam int B_TSTOP = 4;
  localparam int B_TGO   = 5;
  localparam int B_RST   = 7;
  localparam int B_RRA   = 8;
  localparam int B_LCAM  = 9;

  localparam logic [DW-1:0] CMD_MASK   = 16'h03BF;
  localparam logic [DW-1:0] CMD_INIT   = 16'h0094;
  localparam logic [DW-1:0] CFG_MASK   = 16'hBFFF;
  localparam logic [DW-1:0] CFG2_MASK  = 16'hF017;
  localparam logic [DW-1:0] TXC_MASK   = 16'hF000;
  localparam logic [DW-1:0] RXC_MASK   = 16'hFFE0;
  localparam logic [DW-1:0] IMASK_MASK = 16'h7FFF;
  localparam logic [DW-1:0] PTR_MASK   = 16'hFFFE;
  localparam logic [DW-1:0] EOBC_INIT  = 16'h02F8;
  localparam logic [DW-1:0] REV_VALUE  = 16'h0004;
  localparam int            ST_EXH     = 5;

  typedef struct packed {
    logic tx;
    logic rra;
    logic lcam;
    logic tmr_go;
    logic tmr_halt;
    logic rx_on;
    logic rx_off;
  } act_t;
endpackage

// File: rtl/netctl_cmd.sv
module netctl_cmd
  import netctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic [2:0]    done,
  output logic [DW-1:0] cmd_q,
  output act_t          act
);
  logic          blocked, accepted;
  logic [DW-1:0] cmd_n;

  assign blocked  = wr && cmd_q[B_RST] && !wdata[B_RST];
  assign accepted = wr && !blocked;

  always_comb begin
    cmd_n = cmd_q;
    if (done[0]) cmd_n[B_TX]   = 1'b0;
    if (done[1]) cmd_n[B_RRA]  = 1'b0;
    if (done[2]) cmd_n[B_LCAM] = 1'b0;
    if (blocked) begin
      cmd_n[B_RST] = 1'b0;
    end else if (accepted) begin
      cmd_n = cmd_n | (wdata & CMD_MASK);
      if (wdata[B_RXOFF]) cmd_n[B_RXON]  = 1'b0;
      if (wdata[B_RXON])  cmd_n[B_RXOFF] = 1'b0;
      if (wdata[B_TSTOP]) cmd_n[B_TGO]   = 1'b0;
      if (wdata[B_TGO])   cmd_n[B_TSTOP] = 1'b0;
      if (wdata[B_RST]) begin
        cmd_n[B_LCAM]  = 1'b0;
        cmd_n[B_RRA]   = 1'b0;
        cmd_n[B_TX]    = 1'b0;
        cmd_n[B_HALT]  = 1'b0;
        cmd_n[B_RST]   = 1'b1;
        cmd_n[B_RXOFF] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= CMD_INIT;
    else        cmd_q <= cmd_n;
  end

  always_comb begin
    act.tx       = accepted && wdata[B_TX];
    act.rra      = accepted && wdata[B_RRA];
    act.lcam     = accepted && wdata[B_LCAM];
    act.tmr_go   = accepted && wdata[B_TGO];
    act.tmr_halt = accepted && wdata[B_TSTOP];
    act.rx_on    = accepted && wdata[B_RXON];
    act.rx_off   = accepted && wdata[B_RXOFF];
  end

  // R5: a blocked command write only drops the reset bit
  a_r5_reset_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cmd_q[B_RST] && !wdata[B_RST] && done == 3'b000)
      |=> (cmd_q == ($past(cmd_q) & ~(16'h1 << B_RST))));

  // R7: timer start and stop never both latched
  a_r7_timer_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_q[B_TGO] && cmd_q[B_TSTOP]));

  // R13: done retires the latched transmit bit
  a_r13_done_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (done[0] && !wr) |=> !cmd_q[B_TX]);
endmodule

// File: rtl/netctl_irq.sv
module netctl_irq
  import netctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stat,
  input  logic          wr_mask,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] stat_set,
  output logic [DW-1:0] istat_q,
  output logic [DW-1:0] imask_q,
  output logic          rra_req,
  output logic          irq
);
  logic [DW-1:0] clr;

  assign clr     = wr_stat ? (wdata & istat_q) : '0;
  assign rra_req = clr[ST_EXH];
  assign irq     = |(istat_q & imask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      istat_q <= '0;
      imask_q <= '0;
    end else begin
      istat_q <= (istat_q & ~clr) | stat_set;
      if (wr_mask) imask_q <= wdata & IMASK_MASK;
    end
  end

  // R4: top mask bit never stored
  a_r4_mask_msb: assert property (@(posedge clk) disable iff (!rst_n)
    !imask_q[DW-1]);

  // R2: written ones are gone after the edge when nothing sets them
  a_r2_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && stat_set == '0) |=> ((istat_q & $past(wdata)) == '0));

  // R1: zero mask silences the interrupt
  a_r1_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && wdata == '0) |=> !irq);
endmodule

// File: rtl/netctl_cfgregs.sv
module netctl_cfgregs
  import netctl_pkg::*;
#(
  parameter int NPTR   = 4,
  parameter int NTALLY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          in_reset,
  output logic [DW-1:0] rd_val
);
  logic [DW-1:0] cfg_q, cfg2_q, txc_q, rxc_q, seq_q, eobc_q;
  logic [DW-1:0] ptr_q   [NPTR];
  logic [DW-1:0] tally_q [NTALLY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cfg2_q <= '0;
      txc_q  <= '0;
      rxc_q  <= '0;
      seq_q  <= '0;
      eobc_q <= EOBC_INIT;
    end else if (wr) begin
      case (addr)
        A_CFG:  if (in_reset) cfg_q  <= wdata & CFG_MASK;
        A_CFG2: if (in_reset) cfg2_q <= wdata & CFG2_MASK;
        A_TXC:  txc_q  <= wdata & TXC_MASK;
        A_RXC:  rxc_q  <= wdata & RXC_MASK;
        A_SEQ:  seq_q  <= wdata;
        A_EOBC: eobc_q <= wdata;
        default: ;
      endcase
    end
  end

  for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q[gi] <= '0;
      else if (wr && addr == A_PTR0 + AW'(gi)) ptr_q[gi] <= wdata & PTR_MASK;
    end
    // R10: pointers stay even
    a_r10_ptr_even: assert property (@(posedge clk) disable iff (!rst_n)
      !ptr_q[gi][0]);
  end

  for (genvar gt = 0; gt < NTALLY; gt++) begin : g_tally
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tally_q[gt] <= '0;
      else if (wr && addr == A_TAL0 + AW'(gt)) tally_q[gt] <= ~wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    case (addr)
      A_CFG:  rd_val = cfg_q;
      A_CFG2: rd_val = cfg2_q;
      A_TXC:  rd_val = txc_q;
      A_RXC:  rd_val = rxc_q;
      A_SEQ:  rd_val = seq_q;
      A_EOBC: rd_val = eobc_q;
      default: ;
    endcase
    for (int i = 0; i < NPTR; i++)
      if (addr == A_PTR0 + AW'(i)) rd_val = ptr_q[i];
    for (int j = 0; j < NTALLY; j++)
      if (addr == A_TAL0 + AW'(j)) rd_val = tally_q[j];
  end

  // R8: configuration frozen outside reset
  a_r8_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_CFG && !in_reset) |=> $stable(cfg_q));
endmodule

// File: rtl/netctl_regfile.sv
module netctl_regfile
  import netctl_pkg::*;
#(
  parameter int NPTR   = 4,
  parameter int NTALLY = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  input  logic        reg_rd,
  output logic [15:0] reg_rdata,
  input  logic [15:0] stat_set,
  input  logic [2:0]  seq_done,
  output logic        act_tx,
  output logic        act_rra,
  output logic        act_lcam,
  output logic        act_tmr_go,
  output logic        act_tmr_halt,
  output logic        act_rx_on,
  output logic        act_rx_off,
  output logic        irq
);
  logic [DW-1:0] cmd_q, istat_q, imask_q, cfg_rd;
  logic          rra_from_stat;
  act_t          act;
  logic [DW-1:0] rd_mux;

  netctl_cmd u_cmd (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr && reg_addr == A_CMD),
    .wdata (reg_wdata),
    .done  (seq_done),
    .cmd_q (cmd_q),
    .act   (act)
  );

  netctl_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stat  (reg_wr && reg_addr == A_STAT),
    .wr_mask  (reg_wr && reg_addr == A_MASK),
    .wdata    (reg_wdata),
    .stat_set (stat_set),
    .istat_q  (istat_q),
    .imask_q  (imask_q),
    .rra_req  (rra_from_stat),
    .irq      (irq)
  );

  netctl_cfgregs #(.NPTR(NPTR), .NTALLY(NTALLY)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .in_reset (cmd_q[B_RST]),
    .rd_val   (cfg_rd)
  );

  assign act_tx       = act.tx;
  assign act_rra      = act.rra || rra_from_stat;
  assign act_lcam     = act.lcam;
  assign act_tmr_go   = act.tmr_go;
  assign act_tmr_halt = act.tmr_halt;
  assign act_rx_on    = act.rx_on;
  assign act_rx_off   = act.rx_off;

  always_comb begin
    case (reg_addr)
      A_CMD:   rd_mux = cmd_q;
      A_STAT:  rd_mux = istat_q;
      A_MASK:  rd_mux = imask_q;
      A_REV:   rd_mux = REV_VALUE;
      default: rd_mux = cfg_rd;
    endcase
    if (reg_addr >= A_CAM0 && reg_addr <= A_CAM2) rd_mux = '0;
  end

  assign reg_rdata = reg_rd ? rd_mux : '0;

  // R11: revision constant whenever read
  a_r11_rev: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_REV) |-> (reg_rdata == 16'h0004));
endmodule

// File: tb/test_netctl_regfile.sv
module test_netctl_regfile;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_rdata;
  logic [15:0] stat_set = '0;
  logic [2:0]  seq_done = '0;
  logic act_tx, act_rra, act_lcam, act_tmr_go, act_tmr_halt, act_rx_on, act_rx_off, irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;
  logic [6:0] snap;

  always #(PERIOD/2) clk = ~clk;

  netctl_regfile i_netctl_regfile (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .stat_set(stat_set), .seq_done(seq_done), .act_tx(act_tx),
    .act_rra(act_rra), .act_lcam(act_lcam), .act_tmr_go(act_tmr_go),
    .act_tmr_halt(act_tmr_halt), .act_rx_on(act_rx_on),
    .act_rx_off(act_rx_off), .irq(irq)
  );

  // {req[3:0], addr[5:0], wdata[15:0], expected readback[15:0]}
  localparam int NV = 25;
  localparam logic [41:0] VEC [NV] = '{
    {4'd8,  6'h03, 16'hFFFF, 16'hBFFF},  // R8 cfg in reset
    {4'd8,  6'h04, 16'hFFFF, 16'hF017},  // R8 cfg2 in reset
    {4'd9,  6'h05, 16'hFFFF, 16'hF000},  // R9 tx control
    {4'd9,  6'h06, 16'hFFFF, 16'hFFE0},  // R9 rx control
    {4'd10, 6'h08, 16'h1235, 16'h1234},  // R10 pointer
    {4'd10, 6'h0B, 16'hFFFF, 16'hFFFE},  // R10 pointer
    {4'd10, 6'h10, 16'h00FF, 16'hFF00},  // R10 tally
    {4'd10, 6'h12, 16'h0000, 16'hFFFF},  // R10 tally
    {4'd4,  6'h02, 16'hFFFF, 16'h7FFF},  // R4 mask msb
    {4'd11, 6'h14, 16'h1234, 16'h0004},  // R11 revision
    {4'd11, 6'h15, 16'hFFFF, 16'h0000},  // R11 readback port
    {4'd11, 6'h3F, 16'hFFFF, 16'h0000},  // R11 unmapped
    {4'd11, 6'h07, 16'hABCD, 16'hABCD},  // R11 sequence plain
    {4'd11, 6'h0C, 16'h1111, 16'h1111},  // R11 end-of-buffer plain
    {4'd5,  6'h00, 16'h0000, 16'h0014},  // R5 leave reset
    {4'd8,  6'h03, 16'h0000, 16'hBFFF},  // R8 locked
    {4'd8,  6'h04, 16'h0000, 16'hF017},  // R8 locked
    {4'd7,  6'h00, 16'h0008, 16'h0018},  // R7 rx on
    {4'd7,  6'h00, 16'h0020, 16'h0028},  // R7 timer start
    {4'd7,  6'h00, 16'h0004, 16'h0024},  // R7 rx off
    {4'd7,  6'h00, 16'h0010, 16'h0014},  // R7 timer stop
    {4'd6,  6'h00, 16'h0302, 16'h0316},  // R6 or-in
    {4'd6,  6'h00, 16'hFC40, 16'h0316},  // R6 masked bits
    {4'd7,  6'h00, 16'h0080, 16'h0094},  // R7 software reset
    {4'd5,  6'h00, 16'h0002, 16'h0014}   // R5 blocked in reset
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    #(PERIOD/4);
    snap = {act_tx, act_rra, act_lcam, act_tmr_go, act_tmr_halt, act_rx_on, act_rx_off};
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] v);
    reg_addr = a; reg_rd = 1'b1;
    #1;
    v = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd(6'h00, v); chk("R12 cmd", v, 16'h0094);
    rd(6'h01, v); chk("R12 status", v, 16'h0000);
    rd(6'h02, v); chk("R12 mask", v, 16'h0000);
    rd(6'h04, v); chk("R12 cfg2", v, 16'h0000);
    rd(6'h07, v); chk("R12 seq", v, 16'h0000);
    rd(6'h0C, v); chk("R12 eobc", v, 16'h02F8);
    chk("R12 irq", {15'd0, irq}, 16'h0000);
    reg_addr = 6'h14; #1; chk("R11 rd low", reg_rdata, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][37:32], VEC[k][31:16]);
      rd(VEC[k][37:32], v);
      checks++;
      if (v !== VEC[k][15:0]) begin
        fails++;
        $display("FAIL R%0d vector %0d: got %h expected %h", VEC[k][41:38], k, v, VEC[k][15:0]);
      end
    end

    // R6 transmit pulse, order {tx,rra,lcam,go,halt,on,off}
    wr(6'h00, 16'h0002); chk("R6 tx pulse", {9'd0, snap}, 16'h0040);
    rd(6'h00, v); chk("R6 tx latched", v, 16'h0016);
    // R13 done clears transmit
    @(negedge clk); seq_done = 3'b001; @(negedge clk); seq_done = 3'b000;
    rd(6'h00, v); chk("R13 tx done", v, 16'h0014);
    wr(6'h00, 16'h0128); chk("R6 multi pulse", {9'd0, snap}, 16'h002A);
    rd(6'h00, v); chk("R7 multi result", v, 16'h0128);
    @(negedge clk); seq_done = 3'b010; @(negedge clk); seq_done = 3'b000;
    rd(6'h00, v); chk("R13 rra done", v, 16'h0028);
    wr(6'h00, 16'h0080); chk("R6 reset no action pulse", {9'd0, snap}, 16'h0000);
    rd(6'h00, v); chk("R7 reset sets bits", v, 16'h00AC);
    wr(6'h00, 16'h0200); chk("R5 no pulse", {9'd0, snap}, 16'h0000);
    rd(6'h00, v); chk("R5 only reset cleared", v, 16'h002C);
    wr(6'h00, 16'h0280); chk("R6 lcam pulse", {9'd0, snap}, 16'h0010);
    rd(6'h00, v); chk("R7 reset clears lcam", v, 16'h00AC);

    // status and interrupt (mask is 0x7FFF from the table)
    @(negedge clk); stat_set = 16'h00A1; @(negedge clk); stat_set = 16'h0000;
    rd(6'h01, v); chk("R2 set", v, 16'h00A1);
    chk("R1 irq high", {15'd0, irq}, 16'h0001);
    wr(6'h01, 16'h0081); chk("R3 no rra", {15'd0, snap[5]}, 16'h0000);
    rd(6'h01, v); chk("R2 w1c", v, 16'h0020);
    wr(6'h02, 16'h0000); chk("R1 irq masked", {15'd0, irq}, 16'h0000);
    wr(6'h02, 16'h0020); chk("R1 irq unmasked", {15'd0, irq}, 16'h0001);
    wr(6'h01, 16'h0020); chk("R3 rra pulse", {15'd0, snap[5]}, 16'h0001);
    rd(6'h01, v); chk("R2 cleared", v, 16'h0000);
    chk("R1 irq low", {15'd0, irq}, 16'h0000);
    wr(6'h01, 16'h0020); chk("R3 already clear", {15'd0, snap[5]}, 16'h0000);
    @(negedge clk); stat_set = 16'h0001; @(negedge clk); stat_set = 16'h0000;
    @(negedge clk);
    reg_addr = 6'h01; reg_wdata = 16'h0001; reg_wr = 1'b1; stat_set = 16'h0001;
    @(negedge clk);
    reg_wr = 1'b0; stat_set = 16'h0000;
    rd(6'h01, v); chk("R2 set wins", v, 16'h0001);

    finish_run();
  end
endmodule